// File: doc/BRIEF.md
# Single-Precision Floating-Point Multiplier

This block multiplies two binary32 floating-point operands (1 sign bit, 8-bit biased exponent, 23-bit fraction) and returns a binary32 product with an overflow flag and an underflow flag. A 2-bit control input picks one of four rounding modes for each operation. Operations are accepted every clock cycle and the result appears a fixed two clock edges later.

The first pipeline stage splits each operand into its sign, exponent and significand and sorts it into a class (zero, normal, infinity, NaN). It then forms the full 48-bit product of the two 24-bit significands and a 10-bit signed exponent sum, and decides whether the result is a special value. The second stage normalises the product by at most one right shift. It rounds on the guard, round and sticky bits, checks the rounded exponent against both ends of the normal range, and packs the result. Subnormal operands count as zero. Results below the normal range are flushed to zero.

Top module: `fpm_mul`

## Requirements
- R1: For two normal operands the product sign is the XOR of the operand signs, and an exactly representable product is returned exactly (for example 1.5 × 1.5 = 0x40100000).
- R2: With `rnd_mode` = 2'b00 the significand is rounded to the nearest value. An exact halfway case goes to the value with an even last fraction bit.
- R3: With `rnd_mode` = 2'b01 the discarded bits are truncated (rounding toward zero).
- R4: With `rnd_mode` = 2'b10 an inexact result is rounded toward +infinity. With 2'b11 it is rounded toward −infinity.
- R5: When the rounded biased exponent is 255 or more, `ovf_flag` is 1 and `unf_flag` is 0. The result is a signed infinity for mode 00, for mode 10 with a positive result and for mode 11 with a negative result. For all other cases it is the largest finite magnitude (exponent 254, fraction all ones) with the result sign.
- R6: When the rounded biased exponent is 0 or less, the result is a zero with the result sign, `unf_flag` is 1 and `ovf_flag` is 0. A rounded exponent of 1 is returned as a normal number with no flag.
- R7: A NaN operand (exponent 255, fraction non-zero), or zero times infinity, returns 0x7FC00000 with both flags 0.
- R8: Infinity times a non-zero operand returns a signed infinity. Zero times a finite operand returns a signed zero. An operand with exponent field 0 counts as zero. In all of these cases both flags are 0.
- R9: Inputs sampled at one rising clock edge appear on `product` and the flags after the next rising edge. A new operation can be issued every cycle.
- R10: While `rst_n` is low, `product`, `ovf_flag` and `unf_flag` are all 0, cleared asynchronously.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising-edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_a | input | 32 | First binary32 operand |
| op_b | input | 32 | Second binary32 operand |
| rnd_mode | input | 2 | Rounding mode: 00 nearest-even, 01 toward zero, 10 toward +inf, 11 toward −inf |
| product | output | 32 | Rounded binary32 product |
| ovf_flag | output | 1 | Result exceeded the largest finite exponent |
| unf_flag | output | 1 | Result fell below the normal range and was flushed to zero |

## Verification
The pipeline has no handshake, so a corrupted stage-one register shows up on `product` exactly two edges after the operation that loaded it, and only for that one operation. A wrong normalisation choice moves the exponent by one. A wrong guard, round or sticky bit moves the last fraction bit by one in one mode only. Tie vectors in every mode, and back-to-back streams checked against an independent integer model, expose both kinds of error at the cycle they occur. A wrong class decision shows as a lost or spurious flag, or as a non-canonical NaN, on that same output cycle.

// File: rtl/fpm_pkg.sv
package fpm_pkg;

    typedef enum logic [1:0] {
        RM_NEAR_EVEN = 2'b00,
        RM_TO_ZERO   = 2'b01,
        RM_TO_POS    = 2'b10,
        RM_TO_NEG    = 2'b11
    } rmode_e;

    typedef enum logic [1:0] {
        CL_ZERO,
        CL_NORM,
        CL_INF,
        CL_NAN
    } opclass_e;

    typedef enum logic [1:0] {
        RK_NORMAL,
        RK_ZERO,
        RK_INF,
        RK_NAN
    } rkind_e;

endpackage

// File: rtl/fpm_unpack.sv
module fpm_unpack
    import fpm_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic [EXP_W+FRAC_W:0] opnd,
    output logic                  sgn,
    output logic [EXP_W-1:0]      expo,
    output logic [FRAC_W:0]       sig,
    output opclass_e              cls
);
    localparam int W = EXP_W + FRAC_W + 1;

    logic [EXP_W-1:0]  exp_f;
    logic [FRAC_W-1:0] frac_f;

    always_comb begin
        sgn    = opnd[W-1];
        exp_f  = opnd[W-2:FRAC_W];
        frac_f = opnd[FRAC_W-1:0];
        expo   = exp_f;
        sig    = '0;
        if (exp_f == '0) begin
            cls = CL_ZERO;               // subnormals count as zero
        end else if (&exp_f) begin
            cls = (frac_f == '0) ? CL_INF : CL_NAN;
        end else begin
            cls = CL_NORM;
            sig = {1'b1, frac_f};
        end
    end
endmodule

// File: rtl/fpm_round_pack.sv
module fpm_round_pack
    import fpm_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic                       sgn,
    input  rkind_e                     kind,
    input  rmode_e                     mode,
    input  logic [2*(FRAC_W+1)-1:0]    prod,
    input  logic signed [EXP_W+1:0]    exp_sum,
    output logic [EXP_W+FRAC_W:0]      result,
    output logic                       ovf,
    output logic                       unf
);
    localparam int SIG_W  = FRAC_W + 1;
    localparam int PROD_W = 2 * SIG_W;
    localparam int XW     = EXP_W + 2;
    localparam int W      = EXP_W + FRAC_W + 1;
    localparam logic signed [XW-1:0] EXP_TOP = XW'((2 ** EXP_W) - 1);
    localparam logic signed [XW-1:0] EXP_MIN = XW'(1);
    localparam logic [W-1:0] QNAN =
        {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

    logic                    hi;
    logic [PROD_W-1:0]       norm;
    logic [FRAC_W-1:0]       mant;
    logic                    g_bit, r_bit, s_bit, inexact, up;
    logic [FRAC_W:0]         rounded;
    logic signed [XW-1:0]    exp_n, exp_f;
    logic                    to_inf;

    always_comb begin
        hi      = prod[PROD_W-1];
        norm    = hi ? prod : (prod << 1);
        mant    = norm[PROD_W-2 -: FRAC_W];
        g_bit   = norm[PROD_W-2-FRAC_W];
        r_bit   = norm[PROD_W-3-FRAC_W];
        s_bit   = |norm[PROD_W-4-FRAC_W:0];
        inexact = g_bit | r_bit | s_bit;
        exp_n   = exp_sum + XW'(hi);

        unique case (mode)
            RM_NEAR_EVEN: up = g_bit & (r_bit | s_bit | mant[0]);
            RM_TO_ZERO:   up = 1'b0;
            RM_TO_POS:    up = ~sgn & inexact;
            RM_TO_NEG:    up = sgn & inexact;
        endcase

        rounded = {1'b0, mant} + (FRAC_W+1)'(up);
        exp_f   = exp_n + XW'(rounded[FRAC_W]);
        to_inf  = (mode == RM_NEAR_EVEN) | ((mode == RM_TO_POS) & ~sgn)
                | ((mode == RM_TO_NEG) & sgn);

        ovf    = 1'b0;
        unf    = 1'b0;
        result = {sgn, {(W-1){1'b0}}};
        unique case (kind)
            RK_NAN:  result = QNAN;
            RK_INF:  result = {sgn, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
            RK_ZERO: result = {sgn, {(W-1){1'b0}}};
            RK_NORMAL: begin
                if (exp_f >= EXP_TOP) begin
                    ovf    = 1'b1;
                    result = to_inf ? {sgn, {EXP_W{1'b1}}, {FRAC_W{1'b0}}}
                                    : {sgn, {(EXP_W-1){1'b1}}, 1'b0, {FRAC_W{1'b1}}};
                end else if (exp_f < EXP_MIN) begin
                    unf    = 1'b1;
                    result = {sgn, {(W-1){1'b0}}};
                end else begin
                    result = {sgn, exp_f[EXP_W-1:0], rounded[FRAC_W-1:0]};
                end
            end
        endcase
    end
endmodule

// File: rtl/fpm_mul.sv
module fpm_mul
    import fpm_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [EXP_W+FRAC_W:0]    op_a,
    input  logic [EXP_W+FRAC_W:0]    op_b,
    input  logic [1:0]               rnd_mode,
    output logic [EXP_W+FRAC_W:0]    product,
    output logic                     ovf_flag,
    output logic                     unf_flag
);
    localparam int W      = EXP_W + FRAC_W + 1;
    localparam int SIG_W  = FRAC_W + 1;
    localparam int PROD_W = 2 * SIG_W;
    localparam int XW     = EXP_W + 2;
    localparam int BIAS   = (2 ** (EXP_W - 1)) - 1;

    // stage 1: unpack, classify, multiply
    logic [W-1:0]       opnd [2];
    logic               sgn_u  [2];
    logic [EXP_W-1:0]   exp_u  [2];
    logic [SIG_W-1:0]   sig_u  [2];
    opclass_e           cls_u  [2];

    assign opnd[0] = op_a;
    assign opnd[1] = op_b;

    for (genvar i = 0; i < 2; i++) begin : g_unpack
        fpm_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_unpack (
            .opnd (opnd[i]),
            .sgn  (sgn_u[i]),
            .expo (exp_u[i]),
            .sig  (sig_u[i]),
            .cls  (cls_u[i])
        );
    end

    rkind_e                kind_c;
    logic [PROD_W-1:0]     prod_c;
    logic signed [XW-1:0]  exp_c;

    always_comb begin
        prod_c = PROD_W'(sig_u[0]) * PROD_W'(sig_u[1]);
        exp_c  = XW'(exp_u[0]) + XW'(exp_u[1]) - XW'(BIAS);
        if ((cls_u[0] == CL_NAN) || (cls_u[1] == CL_NAN)
            || ((cls_u[0] == CL_ZERO) && (cls_u[1] == CL_INF))
            || ((cls_u[0] == CL_INF) && (cls_u[1] == CL_ZERO)))
            kind_c = RK_NAN;
        else if ((cls_u[0] == CL_INF) || (cls_u[1] == CL_INF))
            kind_c = RK_INF;
        else if ((cls_u[0] == CL_ZERO) || (cls_u[1] == CL_ZERO))
            kind_c = RK_ZERO;
        else
            kind_c = RK_NORMAL;
    end

    logic                  s1_sgn;
    rkind_e                s1_kind;
    rmode_e                s1_mode;
    logic [PROD_W-1:0]     s1_prod;
    logic signed [XW-1:0]  s1_exp;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_sgn  <= 1'b0;
            s1_kind <= RK_ZERO;
            s1_mode <= RM_NEAR_EVEN;
            s1_prod <= '0;
            s1_exp  <= '0;
        end else begin
            s1_sgn  <= sgn_u[0] ^ sgn_u[1];
            s1_kind <= kind_c;
            s1_mode <= rmode_e'(rnd_mode);
            s1_prod <= prod_c;
            s1_exp  <= exp_c;
        end
    end

    // stage 2: normalise, round, pack
    logic [W-1:0] res_c;
    logic         ovf_c, unf_c;

    fpm_round_pack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_round (
        .sgn     (s1_sgn),
        .kind    (s1_kind),
        .mode    (s1_mode),
        .prod    (s1_prod),
        .exp_sum (s1_exp),
        .result  (res_c),
        .ovf     (ovf_c),
        .unf     (unf_c)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            product  <= '0;
            ovf_flag <= 1'b0;
            unf_flag <= 1'b0;
        end else begin
            product  <= res_c;
            ovf_flag <= ovf_c;
            unf_flag <= unf_c;
        end
    end
endmodule

// File: rtl/fpm_mul_chk.sv
module fpm_mul_chk #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [EXP_W+FRAC_W:0] op_a,
    input logic [EXP_W+FRAC_W:0] op_b,
    input logic [1:0]            rnd_mode,
    input logic [EXP_W+FRAC_W:0] product,
    input logic                  ovf_flag,
    input logic                  unf_flag
);
    localparam int W = EXP_W + FRAC_W + 1;
    localparam logic [W-1:0] QNAN =
        {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};
    localparam logic [EXP_W-1:0] EXP_SAT = {{(EXP_W-1){1'b1}}, 1'b0};

    logic [1:0] warm;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          warm <= 2'd0;
        else if (warm != 2'd2) warm <= warm + 2'd1;
    end

    p_sign_xor_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == 2'd2 && product != QNAN)
        |-> product[W-1] == ($past(op_a[W-1], 2) ^ $past(op_b[W-1], 2)));

    p_trunc_sat_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == 2'd2 && ovf_flag && $past(rnd_mode, 2) == 2'b01)
        |-> (product[W-2:FRAC_W] == EXP_SAT && (&product[FRAC_W-1:0])));

    p_ovf_shape_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_flag |-> (!unf_flag &&
            (((&product[W-2:FRAC_W]) && product[FRAC_W-1:0] == '0)
             || (product[W-2:FRAC_W] == EXP_SAT && (&product[FRAC_W-1:0])))));

    p_unf_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        unf_flag |-> (product[W-2:0] == '0 && !ovf_flag));

    p_nan_canon_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((&product[W-2:FRAC_W]) && product[FRAC_W-1:0] != '0)
        |-> (product == QNAN && !ovf_flag && !unf_flag));
endmodule

bind fpm_mul fpm_mul_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_a     (op_a),
    .op_b     (op_b),
    .rnd_mode (rnd_mode),
    .product  (product),
    .ovf_flag (ovf_flag),
    .unf_flag (unf_flag)
);

// File: tb/fpm_mul_bench.sv
`timescale 1ns/1ps
module fpm_mul_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] op_a = '0, op_b = '0;
    logic [1:0]  rnd_mode = 2'b00;
    logic [31:0] product;
    logic        ovf_flag, unf_flag;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    fpm_mul u_fpm_mul (
        .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b),
        .rnd_mode(rnd_mode), .product(product),
        .ovf_flag(ovf_flag), .unf_flag(unf_flag)
    );

    typedef struct packed {
        logic [1:0]  m;
        logic [31:0] a;
        logic [31:0] b;
        logic [31:0] e;
        logic        eo;
        logic        eu;
        logic [15:0] tag;
    } vec_t;

    localparam int NV = 35;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 32'h3F800000, 32'h3F800000, 32'h3F800000, 1'b0, 1'b0, "R1"},
        '{2'd0, 32'h40000000, 32'hC0400000, 32'hC0C00000, 1'b0, 1'b0, "R1"},
        '{2'd0, 32'h3FC00000, 32'h3FC00000, 32'h40100000, 1'b0, 1'b0, "R1"},
        '{2'd0, 32'h3F800001, 32'h3FC00000, 32'h3FC00002, 1'b0, 1'b0, "R2"},
        '{2'd1, 32'h3F800001, 32'h3FC00000, 32'h3FC00001, 1'b0, 1'b0, "R3"},
        '{2'd2, 32'h3F800001, 32'h3FC00000, 32'h3FC00002, 1'b0, 1'b0, "R4"},
        '{2'd3, 32'h3F800001, 32'h3FC00000, 32'h3FC00001, 1'b0, 1'b0, "R4"},
        '{2'd0, 32'h3F800003, 32'h3FC00000, 32'h3FC00004, 1'b0, 1'b0, "R2"},
        '{2'd2, 32'h3F800003, 32'h3FC00000, 32'h3FC00005, 1'b0, 1'b0, "R4"},
        '{2'd0, 32'hBF800003, 32'h3FC00000, 32'hBFC00004, 1'b0, 1'b0, "R2"},
        '{2'd3, 32'hBF800003, 32'h3FC00000, 32'hBFC00005, 1'b0, 1'b0, "R4"},
        '{2'd2, 32'hBF800003, 32'h3FC00000, 32'hBFC00004, 1'b0, 1'b0, "R4"},
        '{2'd1, 32'hBF800001, 32'h3FC00000, 32'hBFC00001, 1'b0, 1'b0, "R3"},
        '{2'd0, 32'h7F7FFFFF, 32'h40000000, 32'h7F800000, 1'b1, 1'b0, "R5"},
        '{2'd1, 32'h7F7FFFFF, 32'h40000000, 32'h7F7FFFFF, 1'b1, 1'b0, "R5"},
        '{2'd2, 32'h7F7FFFFF, 32'h40000000, 32'h7F800000, 1'b1, 1'b0, "R5"},
        '{2'd3, 32'h7F7FFFFF, 32'h40000000, 32'h7F7FFFFF, 1'b1, 1'b0, "R5"},
        '{2'd3, 32'hFF7FFFFF, 32'h40000000, 32'hFF800000, 1'b1, 1'b0, "R5"},
        '{2'd2, 32'hFF7FFFFF, 32'h40000000, 32'hFF7FFFFF, 1'b1, 1'b0, "R5"},
        '{2'd1, 32'hFF7FFFFF, 32'h40000000, 32'hFF7FFFFF, 1'b1, 1'b0, "R5"},
        '{2'd0, 32'h7F7FFFFF, 32'h3F800000, 32'h7F7FFFFF, 1'b0, 1'b0, "R5"},
        '{2'd0, 32'h00800000, 32'h3F000000, 32'h00000000, 1'b0, 1'b1, "R6"},
        '{2'd0, 32'h80800000, 32'h3F000000, 32'h80000000, 1'b0, 1'b1, "R6"},
        '{2'd0, 32'h00800000, 32'h3F800000, 32'h00800000, 1'b0, 1'b0, "R6"},
        '{2'd1, 32'h00FFFFFF, 32'h3F7FFFFF, 32'h00FFFFFE, 1'b0, 1'b0, "R6"},
        '{2'd0, 32'h7F800000, 32'h40000000, 32'h7F800000, 1'b0, 1'b0, "R8"},
        '{2'd0, 32'h7F800000, 32'hC0000000, 32'hFF800000, 1'b0, 1'b0, "R8"},
        '{2'd0, 32'h7F800000, 32'h80000000, 32'h7FC00000, 1'b0, 1'b0, "R7"},
        '{2'd0, 32'h00000000, 32'hFF800000, 32'h7FC00000, 1'b0, 1'b0, "R7"},
        '{2'd0, 32'h7FC00001, 32'h3F800000, 32'h7FC00000, 1'b0, 1'b0, "R7"},
        '{2'd2, 32'hBF800000, 32'hFF800001, 32'h7FC00000, 1'b0, 1'b0, "R7"},
        '{2'd0, 32'h80000000, 32'h40A00000, 32'h80000000, 1'b0, 1'b0, "R8"},
        '{2'd0, 32'h00000001, 32'h3F800000, 32'h00000000, 1'b0, 1'b0, "R8"},
        '{2'd3, 32'h80400000, 32'hC0000000, 32'h00000000, 1'b0, 1'b0, "R8"},
        '{2'd1, 32'h7F800000, 32'h7F800000, 32'h7F800000, 1'b0, 1'b0, "R8"}
    };

    // Independent integer reference: returns {ovf, unf, result}
    function automatic logic [33:0] ref_mul(input logic [31:0] a, input logic [31:0] b,
                                            input logic [1:0] m);
        logic s;
        logic a_nan, b_nan, a_inf, b_inf, a_zero, b_zero, up, big;
        longint unsigned p, q, rem, half;
        int sh, e;
        s      = a[31] ^ b[31];
        a_nan  = (a[30:23] == 8'hFF) && (a[22:0] != 0);
        b_nan  = (b[30:23] == 8'hFF) && (b[22:0] != 0);
        a_inf  = (a[30:23] == 8'hFF) && (a[22:0] == 0);
        b_inf  = (b[30:23] == 8'hFF) && (b[22:0] == 0);
        a_zero = (a[30:23] == 8'h00);
        b_zero = (b[30:23] == 8'h00);
        if (a_nan || b_nan || (a_zero && b_inf) || (a_inf && b_zero))
            return {2'b00, 32'h7FC00000};
        if (a_inf || b_inf) return {2'b00, s, 8'hFF, 23'h0};
        if (a_zero || b_zero) return {2'b00, s, 31'h0};
        p    = 64'({1'b1, a[22:0]}) * 64'({1'b1, b[22:0]});
        sh   = p[47] ? 24 : 23;
        q    = p >> sh;
        rem  = p & ((64'd1 << sh) - 64'd1);
        half = 64'd1 << (sh - 1);
        case (m)
            2'd0:    up = (rem > half) || ((rem == half) && q[0]);
            2'd1:    up = 1'b0;
            2'd2:    up = !s && (rem != 0);
            default: up = s && (rem != 0);
        endcase
        q = q + 64'(up);
        e = int'(a[30:23]) + int'(b[30:23]) - 127 + (sh - 23);
        if (q == (64'd1 << 24)) begin
            q = q >> 1;
            e = e + 1;
        end
        if (e >= 255) begin
            big = (m == 2'd0) || (m == 2'd2 && !s) || (m == 2'd3 && s);
            return {2'b10, big ? {s, 8'hFF, 23'h0} : {s, 8'hFE, 23'h7FFFFF}};
        end
        if (e <= 0) return {2'b01, s, 31'h0};
        return {2'b00, s, e[7:0], q[22:0]};
    endfunction

    task automatic check(input string tag, input logic [31:0] ep,
                         input logic eo, input logic eu);
        n_cmp++;
        if (product !== ep || ovf_flag !== eo || unf_flag !== eu) begin
            n_bad++;
            $display("FAIL %s: got %h ovf=%b unf=%b, expected %h ovf=%b unf=%b",
                     tag, product, ovf_flag, unf_flag, ep, eo, eu);
        end
    endtask

    task automatic apply(input logic [31:0] a, input logic [31:0] b, input logic [1:0] m);
        @(negedge clk);
        op_a = a; op_b = b; rnd_mode = m;
        @(negedge clk);
        @(negedge clk);
    endtask

    function automatic logic [31:0] xs32(input logic [31:0] x);
        logic [31:0] y;
        y = x ^ (x << 13);
        y = y ^ (y >> 17);
        y = y ^ (y << 5);
        return y;
    endfunction

    function automatic logic [31:0] mk_op(input logic [31:0] r1, input logic [31:0] r2);
        logic [7:0] e;
        case (r1[26:24])
            3'd0:    e = r1[7:0];
            3'd1:    e = 8'd190 + {2'b00, r1[5:0]};
            3'd2:    e = 8'd1 + {2'b00, r1[5:0]};
            default: e = 8'd100 + {2'b00, r1[5:0]};
        endcase
        return {r1[31], e, r2[22:0]};
    endfunction

    localparam int NS = 1200;
    logic [31:0] sa [NS];
    logic [31:0] sb [NS];
    logic [1:0]  sm [NS];

    initial begin
        logic [31:0] seed;
        logic [33:0] rr;
        string tg;

        // R10: reset state
        op_a = 32'h3F800000; op_b = 32'h40000000;
        repeat (3) @(negedge clk);
        check("R10 reset held", 32'h0, 1'b0, 1'b0);
        rst_n = 1'b1;

        // table walk
        for (int i = 0; i < NV; i++) begin
            apply(VECS[i].a, VECS[i].b, VECS[i].m);
            check(string'(VECS[i].tag), VECS[i].e, VECS[i].eo, VECS[i].eu);
        end

        // R10: asynchronous clear mid-run, R9: recovery after release
        apply(32'h40000000, 32'hC0400000, 2'b00);
        check("R9 before reset", 32'hC0C00000, 1'b0, 1'b0);
        apply(32'h7F7FFFFF, 32'h40000000, 2'b00);
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R10 async clear", 32'h0, 1'b0, 1'b0);
        @(negedge clk);
        check("R10 still held", 32'h0, 1'b0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R9 after release", 32'h7F800000, 1'b1, 1'b0);

        // R9: back-to-back stream against the reference model
        seed = 32'h1234ABCD;
        for (int i = 0; i < NS; i++) begin
            logic [31:0] r1, r2, r3, r4;
            r1 = xs32(seed); r2 = xs32(r1); r3 = xs32(r2); r4 = xs32(r3);
            seed = r4;
            sa[i] = mk_op(r1, r2);
            sb[i] = mk_op(r3, r4);
            sm[i] = 2'(i % 4);
        end
        for (int i = 0; i < NS + 2; i++) begin
            @(negedge clk);
            if (i >= 2) begin
                rr = ref_mul(sa[i-2], sb[i-2], sm[i-2]);
                if (rr[33])      tg = "R9 stream R5";
                else if (rr[32]) tg = "R9 stream R6";
                else if (sm[i-2] == 2'd0) tg = "R9 stream R2";
                else if (sm[i-2] == 2'd1) tg = "R9 stream R3";
                else             tg = "R9 stream R4";
                check(tg, rr[31:0], rr[33], rr[32]);
            end
            if (i < NS) begin
                op_a = sa[i]; op_b = sb[i]; rnd_mode = sm[i];
            end
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: got no completion, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule